// File: doc/BRIEF.md
# Freezable Statistics Counter Bank

This block keeps a set of event counters for a network MAC. The counters are split into a receive group and a transmit group. Each counter has its own one-cycle event strobe. Software reads the counters through a plain combinational read port. It controls the bank through a single control word at address 0, which holds a freeze bit and two one-shot clear commands, one for each group.

Setting freeze holds every counter at its current value, so software can read a consistent snapshot. Events that arrive while the bank is frozen are not lost. Each clock cycle that carries at least one event stores its event bitmask as one entry in a small queue. When freeze is released, the queue drains one entry per cycle into the counters. Live events that arrive during the drain are counted in the same cycle as the replayed entry. If the queue fills while the bank is frozen, the hardware drops freeze by itself and the drain begins. A clear command zeroes its group at once and also removes that group's pending events from the queue.

Top module: `stat_ctr_bank`

## Requirements
- R1: After synchronous reset, the control word and every counter read zero.
- R2: Event bit i (receive strobes occupy mask bits 0..N_RX-1 and transmit strobes occupy bits N_RX..N_RX+N_TX-1) maps to read address i+1. When the bank is not frozen and the queue is empty, a strobe raises its counter by one, and the new value is readable in the cycle after the strobe.
- R3: A write to address 0 takes wr_data[2] as the freeze bit. Reading address 0 returns freeze in bit 2 and zero in every other bit. Bits 1 and 0 of the control word never read back as 1.
- R4: While freeze reads 1 and no clear is written, every counter keeps its value.
- R5: While frozen, every cycle with at least one strobe adds one queue entry. Once freeze reads 0, one entry is applied per cycle, and the final totals equal those of an unfrozen run.
- R6: During the drain, a live strobe and a replayed entry for the same counter in the same cycle raise that counter by two.
- R7: When a push brings the queue to DEPTH entries, freeze reads 0 in the next cycle and draining starts, even if software has not cleared freeze.
- R8: Writing 1 to wr_data[1] at address 0 zeroes every receive counter in the next cycle. Receive strobes in that cycle and receive bits already in the queue are discarded. Transmit counters are unaffected.
- R9: Writing 1 to wr_data[0] at address 0 does the same for the transmit group: it zeroes every transmit counter, discards transmit strobes in that cycle and transmit bits in the queue, and leaves receive counters unaffected.
- R10: Counters are CNT_W bits wide and wrap from all ones to zero.
- R11: Writes to any address other than 0 change nothing. Reads of addresses above N_RX+N_TX return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_evt | input | N_RX | Receive event strobes, one per counter |
| tx_evt | input | N_TX | Transmit event strobes, one per counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 3 | Control write data: freeze, clear receive, clear transmit |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Combinational read data |

## Verification
The checker assumes that every input has a known value at each rising edge. It also assumes that a write strobe always comes with a valid address and data, and that strobes are sampled levels, not edges. Its queue-room property depends on one fact: freeze can only become 1 through a write, and the queue is always draining in the cycle of that write. The bench drives every input from known values on the falling edge. It mixes frozen and unfrozen periods with clears and with writes to unused addresses, so these conditions always hold.

// File: rtl/stat_pkg.sv
package stat_pkg;

    // Control word: width and bit positions decoded by the control logic
    localparam int CTL_W     = 3;
    localparam int FRZ_POS   = 2;
    localparam int WIPE_RX_POS = 1;
    localparam int WIPE_TX_POS = 0;

    // One-shot commands decoded from a control write
    typedef struct packed {
        logic wipe_rx;
        logic wipe_tx;
    } ctl_cmd_t;

    // Increment for one counter: live strobe plus replayed queue bit
    function automatic logic [1:0] bump(input logic live, input logic replay);
        return {1'b0, live} + {1'b0, replay};
    endfunction

endpackage

// File: rtl/stat_ctl.sv
module stat_ctl
    import stat_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic              auto_release,
    output logic              freeze_q,
    output ctl_cmd_t          cmd
);

    logic ctl_sel;
    logic freeze_d;

    assign ctl_sel = wr_en && (wr_addr == '0);

    always_comb begin
        cmd.wipe_rx = ctl_sel & wr_data[WIPE_RX_POS];
        cmd.wipe_tx = ctl_sel & wr_data[WIPE_TX_POS];
    end

    // A full queue overrides any software value for freeze
    always_comb begin
        freeze_d = ctl_sel ? wr_data[FRZ_POS] : freeze_q;
        if (auto_release) begin
            freeze_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            freeze_q <= 1'b0;
        end else begin
            freeze_q <= freeze_d;
        end
    end

endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    input  logic [W-1:0]                 scrub,
    output logic [W-1:0]                 head,
    output logic                         empty,
    output logic                         full,
    output logic                         last_slot,
    output logic [$clog2(DEPTH+1)-1:0]   level
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp;
    logic [PW-1:0] wp;
    logic [CW-1:0] lvl;

    // Each slot is either written or scrubbed of cleared groups
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[k] <= '0;
            end else if (push && (wp == PW'(k))) begin
                mem[k] <= push_data;
            end else begin
                mem[k] <= mem[k] & ~scrub;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            lvl <= '0;
        end else begin
            if (push) begin
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            case ({push, pop})
                2'b10:   lvl <= lvl + 1'b1;
                2'b01:   lvl <= lvl - 1'b1;
                default: lvl <= lvl;
            endcase
        end
    end

    assign head      = mem[rp];
    assign empty     = (lvl == '0);
    assign full      = (lvl == CW'(DEPTH));
    assign last_slot = (lvl == CW'(DEPTH - 1));
    assign level     = lvl;

endmodule

// File: rtl/ctr_lane.sv
module ctr_lane
    import stat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             live,
    input  logic             replay,
    output logic [CNT_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wipe) begin
            value <= '0;
        end else begin
            value <= value + CNT_W'(bump(live, replay));
        end
    end

endmodule

// File: rtl/stat_ctr_bank.sv
module stat_ctr_bank
    import stat_pkg::*;
#(
    parameter int N_RX   = 4,
    parameter int N_TX   = 4,
    parameter int CNT_W  = 32,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_RX-1:0]   rx_evt,
    input  logic [N_TX-1:0]   tx_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTL_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);

    localparam int N_EV  = N_RX + N_TX;
    localparam int LVL_W = $clog2(DEPTH + 1);

    ctl_cmd_t          cmd;
    logic              freeze_q;
    logic              wipe_rx;
    logic              wipe_tx;
    logic [N_EV-1:0]   evt_all;
    logic [N_EV-1:0]   scrub;
    logic [N_EV-1:0]   kept;
    logic [N_EV-1:0]   head;
    logic              fifo_push;
    logic              fifo_pop;
    logic              fifo_empty;
    logic              fifo_full;
    logic              fifo_last;
    logic              auto_release;
    logic [LVL_W-1:0]  fifo_level;
    logic [CNT_W-1:0]  cnt_arr [N_EV];
    logic [N_RX*CNT_W-1:0] rx_flat;
    logic [N_TX*CNT_W-1:0] tx_flat;

    assign wipe_rx = cmd.wipe_rx;
    assign wipe_tx = cmd.wipe_tx;
    assign evt_all = {tx_evt, rx_evt};
    assign scrub   = {{N_TX{wipe_tx}}, {N_RX{wipe_rx}}};
    assign kept    = evt_all & ~scrub;

    // Frozen cycles with surviving events are queued; unfrozen cycles drain
    assign fifo_push    = freeze_q && (|kept) && !fifo_full;
    assign fifo_pop     = !freeze_q && !fifo_empty;
    assign auto_release = fifo_push && fifo_last;

    stat_ctl #(
        .ADDR_W (ADDR_W)
    ) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .auto_release (auto_release),
        .freeze_q     (freeze_q),
        .cmd          (cmd)
    );

    evt_fifo #(
        .W     (N_EV),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (fifo_push),
        .push_data (kept),
        .pop       (fifo_pop),
        .scrub     (scrub),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .last_slot (fifo_last),
        .level     (fifo_level)
    );

    for (genvar i = 0; i < N_EV; i++) begin : g_lane
        ctr_lane #(
            .CNT_W (CNT_W)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .wipe   (scrub[i]),
            .live   (!freeze_q && evt_all[i]),
            .replay (fifo_pop && head[i]),
            .value  (cnt_arr[i])
        );
        if (i < N_RX) begin : g_rx
            assign rx_flat[i*CNT_W +: CNT_W] = cnt_arr[i];
        end else begin : g_tx
            assign tx_flat[(i-N_RX)*CNT_W +: CNT_W] = cnt_arr[i];
        end
    end

    // Address 0 is the control word, 1..N_EV the counters, the rest zero
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data[FRZ_POS] = freeze_q;
        end
        for (int i = 0; i < N_EV; i++) begin
            if (rd_addr == ADDR_W'(i + 1)) begin
                rd_data = cnt_arr[i];
            end
        end
    end

endmodule

// File: rtl/stat_ctr_bank_chk.sv
module stat_ctr_bank_chk #(
    parameter int N_RX  = 4,
    parameter int N_TX  = 4,
    parameter int CNT_W = 32,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       freeze_q,
    input logic                       push,
    input logic                       wipe_rx,
    input logic                       wipe_tx,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic [N_RX*CNT_W-1:0]      rx_flat,
    input logic [N_TX*CNT_W-1:0]      tx_flat
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    // R4
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze_q && !wipe_rx && !wipe_tx) |=> ($stable(rx_flat) && $stable(tx_flat)));

    // R5
    frozen_room_chk: assert property (@(posedge clk) disable iff (rst)
        freeze_q |-> (level < LVL_W'(DEPTH)));

    // R5
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!freeze_q && (level != '0)) |=> (level == $past(level) - 1'b1));

    // R5
    frozen_no_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze_q && !push) |=> $stable(level));

    // R7
    auto_release_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze_q && push && (level == LVL_W'(DEPTH - 1))) |=> !freeze_q);

    // R8
    wipe_rx_chk: assert property (@(posedge clk) disable iff (rst)
        wipe_rx |=> (rx_flat == '0));

    // R9
    wipe_tx_chk: assert property (@(posedge clk) disable iff (rst)
        wipe_tx |=> (tx_flat == '0));

endmodule

bind stat_ctr_bank stat_ctr_bank_chk #(
    .N_RX  (N_RX),
    .N_TX  (N_TX),
    .CNT_W (CNT_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .freeze_q (freeze_q),
    .push     (fifo_push),
    .wipe_rx  (wipe_rx),
    .wipe_tx  (wipe_tx),
    .level    (fifo_level),
    .rx_flat  (rx_flat),
    .tx_flat  (tx_flat)
);

// File: tb/tb_stat_ctr_bank.sv
`timescale 1ns/1ps
module tb_stat_ctr_bank;

    localparam int CLK_P  = 40;
    localparam int N_RX   = 4;
    localparam int N_TX   = 4;
    localparam int CNT_W  = 8;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 4;
    localparam int N_EV   = N_RX + N_TX;

    logic              clk = 1'b0;
    logic              rst;
    logic [N_RX-1:0]   rx_evt;
    logic [N_TX-1:0]   tx_evt;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [2:0]        wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  rd_data;

    int checks = 0;
    int fails  = 0;

    stat_ctr_bank #(
        .N_RX(N_RX), .N_TX(N_TX), .CNT_W(CNT_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
    ) dut (
        .clk(clk), .rst(rst), .rx_evt(rx_evt), .tx_evt(tx_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural reference model
    logic [CNT_W-1:0] m_cnt [N_EV];
    logic [N_EV-1:0]  m_q [$];
    logic             m_frz;
    logic [N_EV-1:0]  m_scrub, m_live, m_pop;
    logic             m_cr, m_ct, m_pushed, m_nf;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_EV; i++) m_cnt[i] = '0;
            m_q.delete();
            m_frz = 1'b0;
        end else begin
            m_cr = wr_en && (wr_addr == 0) && wr_data[1];
            m_ct = wr_en && (wr_addr == 0) && wr_data[0];
            for (int i = 0; i < N_EV; i++) m_scrub[i] = (i < N_RX) ? m_cr : m_ct;
            m_live = {tx_evt, rx_evt} & ~m_scrub;
            m_pop = '0;
            m_pushed = 1'b0;
            if (m_frz) begin
                if (m_live != 0) begin
                    m_q.push_back(m_live);
                    m_pushed = 1'b1;
                end
            end else if (m_q.size() > 0) begin
                m_pop = m_q.pop_front();
            end
            for (int i = 0; i < N_EV; i++) begin
                if (m_scrub[i]) m_cnt[i] = '0;
                else begin
                    if (!m_frz && m_live[i]) m_cnt[i] = m_cnt[i] + 1'b1;
                    if (m_pop[i]) m_cnt[i] = m_cnt[i] + 1'b1;
                end
            end
            foreach (m_q[k]) m_q[k] = m_q[k] & ~m_scrub;
            m_nf = (wr_en && wr_addr == 0) ? wr_data[2] : m_frz;
            if (m_pushed && m_q.size() == DEPTH) m_nf = 1'b0;
            m_frz = m_nf;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = ADDR_W'(a);
        #1;
        v = int'(rd_data);
    endtask

    // Compare every readable location against the model
    task automatic sweep();
        int v;
        rd(0, v);
        chk("R3 control word", v, m_frz ? 4 : 0);
        for (int a = 1; a <= N_EV; a++) begin
            rd(a, v);
            chk("R2 counter vs model", v, int'(m_cnt[a-1]));
        end
    endtask

    task automatic step(input logic [N_RX-1:0] r, input logic [N_TX-1:0] t,
                        input logic we, input int wa, input logic [2:0] wd);
        rx_evt  = r;
        tx_evt  = t;
        wr_en   = we;
        wr_addr = ADDR_W'(wa);
        wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        rx_evt = '0; tx_evt = '0; wr_en = 1'b0;
        sweep();
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int v, v0, vt;
        rst = 1'b1; rx_evt = '0; tx_evt = '0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: everything zero after reset
        for (int a = 0; a <= N_EV; a++) begin
            rd(a, v);
            chk("R1 reset value", v, 0);
        end

        // R2: single strobes map to addresses
        step(4'b0001, 4'b0000, 0, 0, 3'b000);
        rd(1, v); chk("R2 rx0 increments", v, 1);
        step(4'b0000, 4'b1000, 0, 0, 3'b000);
        rd(8, v); chk("R2 tx3 increments", v, 1);
        for (int n = 0; n < 150; n++)
            step(4'($urandom), 4'($urandom), 0, 0, 3'b000);

        // R3: clear bits never read back
        step(4'b0000, 4'b0000, 1, 0, 3'b100);
        rd(0, v); chk("R3 freeze set, one-shot bits read 0", v, 4);

        // R4 then R6: hold during freeze, then +2 during drain
        rd(1, v0);
        step(4'b0001, 4'b0000, 0, 0, 3'b000);
        rd(1, v); chk("R4 counter held while frozen", v, v0);
        step(4'b0000, 4'b0000, 1, 0, 3'b000);
        rd(0, v); chk("R3 freeze cleared", v, 0);
        step(4'b0001, 4'b0000, 0, 0, 3'b000);
        rd(1, v); chk("R6 live plus replay", v, (v0 + 2) % 256);

        // R7 and R5: fill queue, automatic release, drain
        rd(5, vt);
        step(4'b0000, 4'b0000, 1, 0, 3'b100);
        for (int n = 0; n < DEPTH; n++) step(4'b0000, 4'b0001, 0, 0, 3'b000);
        rd(0, v); chk("R7 freeze released on full", v, 0);
        rd(5, v); chk("R7 counter not yet updated", v, vt);
        for (int n = 0; n < DEPTH; n++) step(4'b0000, 4'b0000, 0, 0, 3'b000);
        rd(5, v); chk("R5 queued events all applied", v, (vt + DEPTH) % 256);

        // R8: clear receive during freeze drops pending receive bits
        rd(5, vt);
        step(4'b0000, 4'b0000, 1, 0, 3'b100);
        step(4'b1111, 4'b0001, 0, 0, 3'b000);
        step(4'b1111, 4'b0000, 1, 0, 3'b110);
        rd(1, v); chk("R8 receive counter zeroed", v, 0);
        rd(5, v); chk("R8 transmit counter untouched", v, vt);
        step(4'b0000, 4'b0000, 1, 0, 3'b000);
        step(4'b0000, 4'b0000, 0, 0, 3'b000);
        step(4'b0000, 4'b0000, 0, 0, 3'b000);
        rd(2, v); chk("R8 pending receive bits discarded", v, 0);
        rd(5, v); chk("R8 pending transmit bit kept", v, (vt + 1) % 256);

        // R9: clear transmit
        step(4'b0010, 4'b0000, 0, 0, 3'b000);
        rd(2, v0);
        step(4'b0000, 4'b1111, 1, 0, 3'b001);
        rd(5, v); chk("R9 transmit counter zeroed", v, 0);
        rd(8, v); chk("R9 transmit strobe in clear cycle dropped", v, 0);
        rd(2, v); chk("R9 receive counter untouched", v, v0);

        // R10: wrap
        step(4'b0000, 4'b0000, 1, 0, 3'b010);
        for (int n = 0; n < 300; n++) step(4'b0100, 4'b0000, 0, 0, 3'b000);
        rd(3, v); chk("R10 counter wraps", v, 300 % 256);

        // R11: other addresses ignored on write, zero on read
        rd(3, v0);
        step(4'b0000, 4'b0000, 1, 5, 3'b111);
        rd(0, v); chk("R11 write elsewhere leaves freeze", v, 0);
        rd(3, v); chk("R11 write elsewhere leaves counters", v, v0);
        rd(12, v); chk("R11 unmapped read is zero", v, 0);

        // Mixed random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic we;
            we = ($urandom % 12) == 0;
            step(4'($urandom), 4'($urandom & $urandom), we,
                 (($urandom % 5) == 0) ? 3 : 0, 3'($urandom));
        end
        report();
    end

endmodule